// File: doc/BRIEF.md
# Bidirectional Line Scanner with Window Blanking

This block models the vertical line scanner of a display panel. A start pulse, taken on a transition of the vertical clock, begins a scan. Every further transition of that clock, rising or falling, moves the selection to the next of 624 lines. The direction input, captured together with the start pulse, makes the scan run from line 0 to line 623 or from line 623 to line 0.

A three-bit mode input picks the height of an active window. The window always sits at the vertical centre of the array. Lines outside the window are not skipped: they are still scanned, but they are flagged as black. A separate black input blanks every line.

The outputs are the selected line index, a gate strobe and a black flag. The gate strobe is high only while the enable input is high. A timing generator drives the vertical clock, the start pulse and the enable. The index and the black flag then steer the line drivers.

Top module: `line_scanner`

## Requirements
- R1: After reset the scanner is idle: line_idx is 0, line_valid is 0 and black is 0.
- R2: A high vst seen in a clk cycle where vck differs from its value in the previous cycle starts a scan at the first line. The first line is 0 when dwn is 1 and 623 when dwn is 0. The new line shows on the outputs after that clk edge.
- R3: Each later vck transition, rising or falling, advances the scan by one line. clk cycles without a vck transition leave the selection unchanged.
- R4: The direction is captured when the scan starts. With dwn=1 the index rises by one per step, and with dwn=0 it falls by one per step. A change of dwn during a scan has no effect on that scan.
- R5: The transition that follows line 623 (down) or line 0 (up) ends the scan. The block then returns to the idle outputs of R1.
- R6: During a scan, line_valid equals enb in the same cycle. While idle, line_valid is 0.
- R7: mode selects the window height N: 0 gives 624, 1 gives 600, 2 gives 572, 3 gives 480 and 4 gives 400. The window starts at line (624−N)/2, which is 0, 12, 26, 72 or 112. During a scan, black is 1 for a selected line below that start, or at or above start+N.
- R8: Mode codes 5, 6 and 7 give the full 624-line window, so black stays 0 unless blk is high.
- R9: While blk is high, black is 1 for every selected line, whatever the mode.
- R10: A start pulse on a vck transition during a scan, including at the last line, restarts the scan at the first line for the dwn value then present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; vck is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vck | input | 1 | Vertical clock; each change of level is one scan step |
| vst | input | 1 | Start pulse, taken on a vck transition |
| dwn | input | 1 | Scan direction: 1 runs 0 to 623, 0 runs 623 to 0 |
| enb | input | 1 | Gate enable; lets the selected line drive its gate |
| blk | input | 1 | Forces every line black |
| mode | input | 3 | Active window height code |
| line_idx | output | 10 | Index of the selected line, 0 when idle |
| line_valid | output | 1 | Gate strobe for the selected line |
| black | output | 1 | Selected line is to be shown black |

## Verification
A start pulse and the end of a scan can fall on the same vck transition. This happens when vst is high on the transition that would otherwise retire the last line. In that case the restart must win, so the next cycle shows the first line of a fresh scan and not the idle state. The bench provokes this at the end of a downward scan. It also restarts a scan in the middle of its run. In both cases it judges the result by the index, strobe and black flag in the cycle after the edge. The sweep over all eight mode codes in both directions compares every line against a window computed from the mode arithmetic.

// File: rtl/line_scanner.sv
module line_scanner #(
  parameter int LINES  = 624,
  parameter int W_M1   = 600,
  parameter int W_M2   = 572,
  parameter int W_M3   = 480,
  parameter int W_M4   = 400,
  localparam int IW    = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vck,
  input  logic          vst,
  input  logic          dwn,
  input  logic          enb,
  input  logic          blk,
  input  logic [2:0]    mode,
  output logic [IW-1:0] line_idx,
  output logic          line_valid,
  output logic          black
);

  localparam logic [IW-1:0] LAST = IW'(LINES - 1);

  logic          vck_q, active, dir_q;
  logic [IW-1:0] pos, idx, win, off;
  logic          vedge, in_win;

  assign vedge = vck ^ vck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vck_q  <= 1'b0;
      active <= 1'b0;
      dir_q  <= 1'b1;
      pos    <= '0;
    end else begin
      vck_q <= vck;
      if (vedge) begin
        if (vst) begin
          active <= 1'b1;
          pos    <= '0;
          dir_q  <= dwn;
        end else if (active) begin
          if (pos == LAST) begin
            active <= 1'b0;
            pos    <= '0;
          end else begin
            pos <= pos + IW'(1);
          end
        end
      end
    end
  end

  assign idx = dir_q ? pos : LAST - pos;

  always_comb begin
    case (mode)
      3'd1:    win = IW'(W_M1);
      3'd2:    win = IW'(W_M2);
      3'd3:    win = IW'(W_M3);
      3'd4:    win = IW'(W_M4);
      default: win = IW'(LINES);
    endcase
  end

  assign off    = IW'((IW'(LINES) - win) >> 1);
  assign in_win = ({1'b0, idx} >= {1'b0, off}) &&
                  ({1'b0, idx} <  ({1'b0, off} + {1'b0, win}));

  assign line_idx   = active ? idx : '0;
  assign line_valid = active & enb;
  assign black      = active & (blk | ~in_win);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vedge && vst) |=> (active && pos == '0));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vedge && !vst && active && pos != LAST) |=> (active && pos == $past(pos) + IW'(1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vedge |=> ($stable(pos) && $stable(active)));

  assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vedge && !vst && active && pos == LAST) |=> !active);

  assert_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(vedge && vst) |=> $stable(dir_q));

  assert_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !blk && mode > 3'd4) |-> !black);

endmodule

// File: tb/tb_line_scanner.sv
module tb_line_scanner;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vck = 1'b0, vst = 1'b0, dwn = 1'b1, enb = 1'b0, blk = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [9:0] line_idx;
  logic line_valid, black;
  int errors = 0, checks = 0, cyc = 0;

  line_scanner dut (.clk(clk), .rst_n(rst_n), .vck(vck), .vst(vst), .dwn(dwn),
    .enb(enb), .blk(blk), .mode(mode), .line_idx(line_idx),
    .line_valid(line_valid), .black(black));

  always #5 clk = ~clk;

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic st);
    @(negedge clk);
    vck = ~vck; vst = st;
    @(posedge clk); #1;
    vst = 1'b0;
  endtask

  function automatic int win_of(input int m);
    case (m)
      1: return 600; 2: return 572; 3: return 480; 4: return 400;
      default: return 624;
    endcase
  endfunction

  task automatic expect_line(input int k, input int d, input int m, input int b, input string tag);
    int idx, n, o, bl;
    idx = d ? k : 623 - k;
    n = win_of(m); o = (624 - n) / 2;
    bl = (b != 0 || idx < o || idx >= o + n) ? 1 : 0;
    chk({tag, " idx R4"}, int'(line_idx), idx);
    chk({tag, " black R7 R8 R9"}, int'(black), bl);
    chk({tag, " valid R6"}, int'(line_valid), int'(enb));
  endtask

  task automatic expect_idle(input string tag);
    chk({tag, " idle idx R5"}, int'(line_idx), 0);
    chk({tag, " idle valid R5"}, int'(line_valid), 0);
    chk({tag, " idle black R5"}, int'(black), 0);
  endtask

  task automatic scan(input int m, input int d, input int b);
    mode = 3'(m); dwn = d[0]; blk = b[0]; enb = 1'b0;
    step(1'b1);
    expect_line(0, d, m, b, "start R2");
    for (int k = 1; k < 624; k++) begin
      enb = k[0] ^ k[3];
      if (k == 300) dwn = ~dwn;
      step(1'b0);
      expect_line(k, d, m, b, "scan R3");
      if (k == 157) begin
        repeat (3) @(posedge clk);
        #1 expect_line(k, d, m, b, "no edge R3");
      end
    end
    enb = 1'b1; blk = 1'b1;
    step(1'b0);
    expect_idle("end");
    blk = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 enb = 1'b1; blk = 1'b1;
    expect_idle("reset R1");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    expect_idle("after reset R1");
    step(1'b0);
    expect_idle("edge without start R2");
    blk = 1'b0;

    for (int m = 0; m < 8; m++)
      for (int d = 0; d < 2; d++)
        scan(m, d, 0);
    scan(3, 1, 1);
    scan(0, 0, 1);

    mode = 3'd2; dwn = 1'b1;
    step(1'b1);
    for (int k = 1; k < 50; k++) step(1'b0);
    expect_line(49, 1, 2, 0, "pre-restart R10");
    dwn = 1'b0;
    step(1'b1);
    expect_line(0, 0, 2, 0, "mid restart R10");

    dwn = 1'b1; mode = 3'd4;
    step(1'b1);
    for (int k = 1; k < 624; k++) step(1'b0);
    expect_line(623, 1, 4, 0, "last line R10");
    step(1'b1);
    expect_line(0, 1, 4, 0, "restart at end R10");
    step(1'b0);
    expect_line(1, 1, 4, 0, "after restart R3");

    report();
  end
endmodule